// File: doc/BRIEF.md
# DMA Channel Completion Event Accounting Unit

This unit keeps the event bookkeeping for one DMA channel. Every completion pulse from the channel engine advances a wrapping done counter, whether the pulse reports that a command list was loaded or that a command finished. Software keeps its own wrapping processed count in the same register. The unit raises a level-sensitive, active-high interrupt while the two counts disagree or while a sticky active flag is set.

Software services the channel by reading the register, taking the done count, and writing it back into the processed field with the active bit at zero. The done count can move between that read and that write, so a write never touches the done count. A pulse that lands in the same cycle as the acknowledge write advances the done count and sets the active flag again, so the event is not lost. A channel cancel clears all three pieces of state.

The register has fixed field positions: done count in bits 5:0, active flag in bit 8, processed count in bits 21:16. All other bits read as zero and are ignored on write.

Top module: `dma_evt_acct`

## Requirements
- R1: After reset the register reads 0, the pending count is 0 and the interrupt is low.
- R2: Each cycle with `evt_pulse` high and `chan_clr` low advances the done count (bits 5:0) by one, modulo 64, so 63 wraps to 0. This is visible from the next cycle.
- R3: A write stores `reg_wdata[21:16]` as the processed count from the next cycle. A write never changes the done count, whatever `reg_wdata[5:0]` holds.
- R4: A write with `reg_wdata[8]` = 0 and no event in the same cycle clears the active flag (bit 8). A write with `reg_wdata[8]` = 1 leaves the flag unchanged.
- R5: An event sets the active flag from the next cycle. This holds when the event arrives in the same cycle as a clearing write, and that event's count step is kept.
- R6: `irq` is high exactly when `irq_en` is 1 and either done differs from processed or the active flag is 1. It follows `irq_en` in the same cycle.
- R7: `pend_cnt` equals (done − processed) modulo 64.
- R8: A cycle with `chan_clr` high zeroes done, processed and active from the next cycle. It takes priority over an event or a write in that same cycle.
- R9: `reg_rdata` shows done in bits 5:0, active in bit 8 and processed in bits 21:16, with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_clr | input | 1 | Channel cancel: clears all counts and the flag |
| evt_pulse | input | 1 | One completion event per cycle high |
| irq_en | input | 1 | Interrupt enable |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| pend_cnt | output | 6 | Unacknowledged events, modulo 64 |
| irq | output | 1 | Level interrupt, active high |

## Verification
The hardest case to reach is the race: an event in the same cycle as an acknowledge write that clears the active flag and makes processed equal to the current done count. The stimulus first advances done to a known value. It then drives the write and the pulse together and checks that done moved by one, that the flag is set, that one event is pending and that the interrupt stays up. A second hard spot is wraparound of both counters. To reach it, more than 64 events are applied and then every processed value from 0 to 63 is written, with the pending count checked arithmetically for each one.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
    parameter int CNT_W    = 6;   // width of both counters
    parameter int REG_W    = 32;  // register width
    parameter int DONE_LSB = 0;   // done field position
    parameter int ACT_BIT  = 8;   // active flag position
    parameter int PROC_LSB = 16;  // processed field position
endpackage

// File: rtl/dma_evt_done_ctr.sv
module dma_evt_done_ctr #(
    parameter int CW = dma_evt_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          evt,
    output logic [CW-1:0] done
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.cnt = '0;
        else if (evt)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.cnt;
endmodule

// File: rtl/dma_evt_ack_reg.sv
module dma_evt_ack_reg #(
    parameter int CW = dma_evt_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          evt,
    input  logic          we,
    input  logic [CW-1:0] wr_proc,
    input  logic          wr_act,
    output logic [CW-1:0] proc,
    output logic          active
);
    typedef struct packed {
        logic [CW-1:0] proc;
        logic          act;
    } ack_t;

    ack_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (we)
                st_d.proc = wr_proc;
            if (evt)
                st_d.act = 1'b1;
            else if (we && !wr_act)
                st_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign proc   = st_q.proc;
    assign active = st_q.act;
endmodule

// File: rtl/dma_evt_acct.sv
module dma_evt_acct #(
    parameter int CW       = dma_evt_pkg::CNT_W,
    parameter int DW       = dma_evt_pkg::REG_W,
    parameter int DONE_LSB = dma_evt_pkg::DONE_LSB,
    parameter int ACT_BIT  = dma_evt_pkg::ACT_BIT,
    parameter int PROC_LSB = dma_evt_pkg::PROC_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_clr,
    input  logic          evt_pulse,
    input  logic          irq_en,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [CW-1:0] pend_cnt,
    output logic          irq
);
    logic [CW-1:0] done_w;
    logic [CW-1:0] proc_w;
    logic          act_w;
    logic          unused_wbits;

    assign unused_wbits = ^reg_wdata;

    dma_evt_done_ctr #(.CW(CW)) u_done (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (chan_clr),
        .evt   (evt_pulse),
        .done  (done_w)
    );

    dma_evt_ack_reg #(.CW(CW)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (chan_clr),
        .evt     (evt_pulse),
        .we      (reg_we),
        .wr_proc (reg_wdata[PROC_LSB +: CW]),
        .wr_act  (reg_wdata[ACT_BIT]),
        .proc    (proc_w),
        .active  (act_w)
    );

    always_comb begin
        reg_rdata = '0;
        reg_rdata[DONE_LSB +: CW] = done_w;
        reg_rdata[PROC_LSB +: CW] = proc_w;
        reg_rdata[ACT_BIT]        = act_w;
    end

    assign pend_cnt = done_w - proc_w;
    assign irq      = irq_en && ((done_w != proc_w) || act_w);
endmodule

// File: rtl/dma_evt_acct_chk.sv
module dma_evt_acct_chk #(
    parameter int CW       = dma_evt_pkg::CNT_W,
    parameter int DW       = dma_evt_pkg::REG_W,
    parameter int DONE_LSB = dma_evt_pkg::DONE_LSB,
    parameter int ACT_BIT  = dma_evt_pkg::ACT_BIT,
    parameter int PROC_LSB = dma_evt_pkg::PROC_LSB
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chan_clr,
    input logic          evt_pulse,
    input logic          irq_en,
    input logic          reg_we,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic [CW-1:0] pend_cnt,
    input logic          irq
);
    logic [CW-1:0] c_done, c_proc, c_wproc;
    logic          c_act;
    logic          unused_chk;

    assign c_done     = reg_rdata[DONE_LSB +: CW];
    assign c_proc     = reg_rdata[PROC_LSB +: CW];
    assign c_act      = reg_rdata[ACT_BIT];
    assign c_wproc    = reg_wdata[PROC_LSB +: CW];
    assign unused_chk = ^{reg_wdata, pend_cnt};

    AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse && !chan_clr) |=> (c_done == CW'($past(c_done) + 1'b1))); // R2
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_pulse && !chan_clr) |=> $stable(c_done)); // R3
    AST_PROC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !chan_clr) |=> (c_proc == $past(c_wproc))); // R3
    AST_ACT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_wdata[ACT_BIT] && !evt_pulse && !chan_clr) |=> !c_act); // R4
    AST_ACT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse && !chan_clr) |=> c_act); // R5
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en); // R6
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_done == c_proc && !c_act) |-> !irq); // R6
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        chan_clr |=> (reg_rdata == '0)); // R8
endmodule

bind dma_evt_acct dma_evt_acct_chk #(
    .CW(CW), .DW(DW), .DONE_LSB(DONE_LSB), .ACT_BIT(ACT_BIT), .PROC_LSB(PROC_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_clr  (chan_clr),
    .evt_pulse (evt_pulse),
    .irq_en    (irq_en),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pend_cnt  (pend_cnt),
    .irq       (irq)
);

// File: tb/sim_dma_evt_acct.sv
module sim_dma_evt_acct;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_clr = 1'b0;
    logic        evt_pulse = 1'b0;
    logic        irq_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  pend_cnt;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 0;

    int m_done = 0, m_proc = 0;
    bit m_act = 0;

    always #2.5 clk = ~clk;

    dma_evt_acct u0 (
        .clk(clk), .rst_n(rst_n), .chan_clr(chan_clr), .evt_pulse(evt_pulse),
        .irq_en(irq_en), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pend_cnt(pend_cnt), .irq(irq)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int e_rd;
        bit e_irq;
        e_rd  = (m_proc << 16) | (int'(m_act) << 8) | m_done;
        e_irq = irq_en && ((m_done != m_proc) || m_act);
        chk(tag, "rdata", int'(reg_rdata), e_rd);
        chk(tag, "irq", int'(irq), int'(e_irq));
        chk(tag, "pend", int'(pend_cnt), (m_done - m_proc) & 63);
    endtask

    task automatic step(input bit e, input bit w, input logic [31:0] wd,
                        input bit c, input string tag);
        @(negedge clk);
        evt_pulse = e; reg_we = w; reg_wdata = wd; chan_clr = c;
        @(negedge clk);
        evt_pulse = 0; reg_we = 0; chan_clr = 0;
        if (c) begin
            m_done = 0; m_proc = 0; m_act = 0;
        end else begin
            if (e) m_done = (m_done + 1) & 63;
            if (w) m_proc = int'(wd[21:16]);
            if (e) m_act = 1;
            else if (w && !wd[8]) m_act = 0;
        end
        #1;
        compare(tag);
    endtask

    function automatic logic [31:0] wr(input int p, input bit a, input int junk);
        return (32'(p & 63) << 16) | (32'(a) << 8) | (32'(junk) & 32'hFFC0_FEC0) | 32'(junk & 63);
    endfunction

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        irq_en = 1;
        #1;
        compare("R1");

        // R2: 70 events, wrapping past 63
        for (int i = 0; i < 70; i++) step(1, 0, '0, 0, "R2");

        // R3: write with garbage in the done field and elsewhere
        step(0, 1, wr(5, 1, 32'hFFFF_FFFF), 0, "R3");

        // R7: sweep every processed value, flag kept set
        for (int p = 0; p < 64; p++) step(0, 1, wr(p, 1, 0), 0, "R7");

        // R4: bit8 = 1 keeps the flag, bit8 = 0 clears it
        step(0, 1, wr(m_done, 1, 0), 0, "R4");
        step(0, 1, wr(m_done, 0, 0), 0, "R4");

        // R6: idle means no interrupt; difference alone raises it
        step(0, 0, '0, 0, "R6");
        step(0, 1, wr(m_done + 1, 0, 0), 0, "R6");
        @(negedge clk); irq_en = 0; #1; compare("R6");
        @(negedge clk); irq_en = 1; #1; compare("R6");
        step(0, 1, wr(m_done, 0, 0), 0, "R6");

        // R5: event races with clearing acknowledge
        for (int i = 0; i < 3; i++) step(1, 0, '0, 0, "R2");
        step(0, 1, wr(m_done, 0, 0), 0, "R4");
        step(1, 1, wr(m_done, 0, 0), 0, "R5");
        step(0, 1, wr(m_done, 0, 0), 0, "R5");

        // R9: distinct field values read back
        for (int i = 0; i < 9; i++) step(1, 0, '0, 0, "R2");
        step(0, 1, wr(42, 1, 0), 0, "R9");

        // R8: clear overrides an event and a write in the same cycle
        step(1, 1, wr(17, 1, 0), 1, "R8");
        step(1, 0, '0, 0, "R2");
        step(0, 0, '0, 1, "R8");

        finish_up();
    end
endmodule